// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns the input pins of a GPIO bank into interrupt requests. Each pin is first brought into the core clock domain through a flop chain. It is then judged according to its own configuration bits. A pin can be edge sensitive or level sensitive, can be active on its high or its low side, and can be set to fire on any transition at all. Edge events are held in a per-pin sticky flag until software writes a one to that pin's bit in the end-of-interrupt vector. Level events carry no state and track the synchronized pin.

The block reports two vectors and one request line. The raw vector shows every pending pin. The reported vector keeps only the pins that are enabled and not masked. A single request output is the registered OR of the reported vector. The intended use is to tie every enable bit high and use the mask bits as the only gate. Masking a pin hides it from the reported vector but leaves its sticky flag in place, so software can unmask it later and still find the event.

Top module: `gpio_irq_detect`

## Requirements
- R1: With every pin configured as edge sensitive and all pins held low through reset, the raw vector, the reported vector and `irq` read all zeros after reset is released.
- R2: An edge-sensitive pin (type bit 1) with polarity bit 1 and both-edge bit 0 sets its raw bit on a low-to-high transition, and a high-to-low transition does not set it.
- R3: An edge-sensitive pin with polarity bit 0 and both-edge bit 0 sets its raw bit on a high-to-low transition, and a low-to-high transition does not set it.
- R4: An edge-sensitive pin with its both-edge bit at 1 sets its raw bit on either transition, whatever its polarity bit is.
- R5: A latched edge stays set after the pin returns to its idle level. It is cleared only by a cycle with `eoi_wr` high and a 1 in that pin's bit of `eoi_bits`. Pins whose `eoi_bits` bit is 0 keep their flags.
- R6: A level-sensitive pin (type bit 0) shows raw 1 exactly while its synchronized value equals its polarity bit (1 means active high, 0 means active low). An end-of-interrupt write has no effect on it.
- R7: A mask bit of 1 removes the pin from the reported vector while its raw bit stays set. Clearing the mask bit brings the pending event back into the reported vector.
- R8: An enable bit of 0 removes the pin from the reported vector.
- R9: `irq` equals the OR of the reported vector one clock later.
- R10: If a new edge arrives in the same cycle as an end-of-interrupt clear for that pin, the pin stays latched.
- R11: Pins pass through a two-flop synchronizer. A level pin's raw bit follows a pin change after two rising clock edges. An edge pin's raw bit sets after three rising clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| cfg_enable | input | NUM_PINS | Per-pin enable; 1 lets the pin report |
| cfg_mask | input | NUM_PINS | Per-pin mask; 1 hides the pin from reported status |
| cfg_type | input | NUM_PINS | 1 = edge sensitive, 0 = level sensitive |
| cfg_polarity | input | NUM_PINS | 1 = rising / active high, 0 = falling / active low |
| cfg_both | input | NUM_PINS | 1 = latch either transition (edge pins) |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_bits | input | NUM_PINS | Pins to clear on an end-of-interrupt write |
| raw_status | output | NUM_PINS | Pending pins before enable and mask |
| int_status | output | NUM_PINS | Pending pins that are enabled and unmasked |
| irq | output | 1 | Registered OR of `int_status` |

## Verification
The assertions take the configuration inputs to be quasi-static: the hold and cause checks on latched edges only apply while a pin's type bit stays at 1 across the cycles they compare. They also take the pins to be free of glitches shorter than a clock, because the edge-cause check reasons from the synchronizer output alone. The bench keeps within these limits. It changes configuration bits only while the affected pin is quiet. It drives pins and strobes on the falling clock edge and holds each pin level for several cycles. Its one deliberate overlap lines up the end-of-interrupt strobe with the cycle in which the synchronized edge is visible.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // Transition test on the synchronized sample against the previous one.
   function automatic logic edge_hit(input logic cur, input logic prev,
                                     input logic rise_sel, input logic any_sel);
      if (any_sel)
         return cur ^ prev;
      return rise_sel ? (cur & ~prev) : (~cur & prev);
   endfunction

   // Level pin is active when its sample equals the selected active side.
   function automatic logic level_active(input logic cur, input logic high_sel);
      return ~(cur ^ high_sel);
   endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync,
   output logic [WIDTH-1:0] q_prev
);

   localparam int LAST = STAGES - 1;

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d_async;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else        chain[s] <= chain[s-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_prev <= '0;
      else        q_prev <= chain[LAST];
   end

   assign q_sync = chain[LAST];

endmodule

// File: rtl/gpio_irq_edge_bank.sv
module gpio_irq_edge_bank #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] smp_cur,
   input  logic [WIDTH-1:0] smp_prev,
   input  logic [WIDTH-1:0] sel_edge,
   input  logic [WIDTH-1:0] sel_high,
   input  logic [WIDTH-1:0] sel_any,
   input  logic [WIDTH-1:0] clr_vec,
   output logic [WIDTH-1:0] pend
);

   import gpio_irq_pkg::*;

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic hit;
      logic sticky_q;

      assign hit = edge_hit(smp_cur[i], smp_prev[i], sel_high[i], sel_any[i]);

      // A new edge outranks a clear arriving in the same cycle.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            sticky_q <= 1'b0;
         else if (!sel_edge[i]) sticky_q <= 1'b0;
         else                   sticky_q <= hit | (sticky_q & ~clr_vec[i]);
      end

      assign pend[i] = sel_edge[i] ? sticky_q
                                   : level_active(smp_cur[i], sel_high[i]);
   end

endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] pend,
   input  logic [WIDTH-1:0] en,
   input  logic [WIDTH-1:0] msk,
   output logic [WIDTH-1:0] visible,
   output logic             req
);

   assign visible = pend & en & ~msk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req <= 1'b0;
      else        req <= |visible;
   end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int NUM_PINS    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic [NUM_PINS-1:0] cfg_enable,
   input  logic [NUM_PINS-1:0] cfg_mask,
   input  logic [NUM_PINS-1:0] cfg_type,
   input  logic [NUM_PINS-1:0] cfg_polarity,
   input  logic [NUM_PINS-1:0] cfg_both,
   input  logic                eoi_wr,
   input  logic [NUM_PINS-1:0] eoi_bits,
   output logic [NUM_PINS-1:0] raw_status,
   output logic [NUM_PINS-1:0] int_status,
   output logic                irq
);

   if (NUM_PINS < 1 || NUM_PINS > 32) begin : g_bad_width
      $error("gpio_irq_detect: NUM_PINS must lie in 1..32");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_irq_detect: SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] sync_q;
   logic [NUM_PINS-1:0] sync_prev;
   logic [NUM_PINS-1:0] clr_vec;

   assign clr_vec = eoi_wr ? eoi_bits : '0;

   gpio_irq_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_in),
      .q_sync  (sync_q),
      .q_prev  (sync_prev)
   );

   gpio_irq_edge_bank #(.WIDTH(NUM_PINS)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_cur  (sync_q),
      .smp_prev (sync_prev),
      .sel_edge (cfg_type),
      .sel_high (cfg_polarity),
      .sel_any  (cfg_both),
      .clr_vec  (clr_vec),
      .pend     (raw_status)
   );

   gpio_irq_combine #(.WIDTH(NUM_PINS)) u_comb (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend    (raw_status),
      .en      (cfg_enable),
      .msk     (cfg_mask),
      .visible (int_status),
      .req     (irq)
   );

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
   parameter int NUM_PINS = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_PINS-1:0] sync_q,
   input logic [NUM_PINS-1:0] sync_prev,
   input logic [NUM_PINS-1:0] cfg_type,
   input logic [NUM_PINS-1:0] cfg_enable,
   input logic [NUM_PINS-1:0] cfg_mask,
   input logic                eoi_wr,
   input logic [NUM_PINS-1:0] eoi_bits,
   input logic [NUM_PINS-1:0] raw_status,
   input logic [NUM_PINS-1:0] int_status,
   input logic                irq
);

   logic                past_ok;
   logic [NUM_PINS-1:0] clr_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assign clr_seen = eoi_wr ? eoi_bits : '0;

   AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (irq == $past(|int_status)));                           // R9

   AST_REPORT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      (int_status & ~raw_status) == '0);                                 // R7

   AST_GATED_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
      (int_status & (cfg_mask | ~cfg_enable)) == '0);                    // R8

   AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (($past(raw_status & cfg_type & ~clr_seen) & cfg_type
                    & $past(cfg_type) & ~raw_status) == '0));            // R5

   AST_EDGE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> ((raw_status & ~$past(raw_status) & cfg_type & $past(cfg_type)
                    & ~$past(sync_q ^ sync_prev)) == '0));               // R2

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sync_q     (sync_q),
   .sync_prev  (sync_prev),
   .cfg_type   (cfg_type),
   .cfg_enable (cfg_enable),
   .cfg_mask   (cfg_mask),
   .eoi_wr     (eoi_wr),
   .eoi_bits   (eoi_bits),
   .raw_status (raw_status),
   .int_status (int_status),
   .irq        (irq)
);

// File: tb/gpio_irq_detect_bench.sv
module gpio_irq_detect_bench;

   localparam int N = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] pin_in = '0;
   logic [N-1:0] cfg_enable = '1;
   logic [N-1:0] cfg_mask = '0;
   logic [N-1:0] cfg_type = '1;
   logic [N-1:0] cfg_polarity = '1;
   logic [N-1:0] cfg_both = '0;
   logic         eoi_wr = 1'b0;
   logic [N-1:0] eoi_bits = '0;
   logic [N-1:0] raw_status;
   logic [N-1:0] int_status;
   logic         irq;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   gpio_irq_detect #(.NUM_PINS(N), .SYNC_STAGES(2)) u_gpio_irq_detect (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
      .cfg_enable(cfg_enable), .cfg_mask(cfg_mask), .cfg_type(cfg_type),
      .cfg_polarity(cfg_polarity), .cfg_both(cfg_both),
      .eoi_wr(eoi_wr), .eoi_bits(eoi_bits),
      .raw_status(raw_status), .int_status(int_status), .irq(irq)
   );

   task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drive_pin(input int p, input logic v);
      @(negedge clk);
      pin_in[p] = v;
   endtask

   task automatic clear_pins(input logic [N-1:0] bits);
      @(negedge clk);
      eoi_wr = 1'b1;
      eoi_bits = bits;
      @(negedge clk);
      eoi_wr = 1'b0;
      eoi_bits = '0;
   endtask

   task automatic t_reset;
      chk("R1 raw after reset", raw_status, '0);
      chk("R1 status after reset", int_status, '0);
      chk("R1 irq after reset", {{(N-1){1'b0}}, irq}, '0);
   endtask

   task automatic t_rising;
      drive_pin(0, 1'b1);
      wait_neg(2);
      chk("R11 edge not yet latched after 2 edges", raw_status, '0);
      wait_neg(1);
      chk("R11 R2 rising latched after 3 edges", raw_status, 32'h1);
      chk("R9 irq lags status", {{(N-1){1'b0}}, irq}, '0);
      wait_neg(1);
      chk("R9 irq one cycle later", {{(N-1){1'b0}}, irq}, 32'h1);
      drive_pin(0, 1'b0);
      wait_neg(4);
      chk("R5 latch held after pin returns", raw_status, 32'h1);
      clear_pins(32'h1);
      chk("R5 cleared by eoi", raw_status, '0);
      cfg_polarity[0] = 1'b1;
      drive_pin(0, 1'b1);
      wait_neg(4);
      clear_pins(32'h1);
      drive_pin(0, 1'b0);
      wait_neg(4);
      chk("R2 falling ignored on rising pin", raw_status, '0);
   endtask

   task automatic t_falling;
      cfg_polarity[1] = 1'b0;
      drive_pin(1, 1'b1);
      wait_neg(4);
      chk("R3 rising ignored on falling pin", raw_status, '0);
      drive_pin(1, 1'b0);
      wait_neg(4);
      chk("R3 falling latched", raw_status, 32'h2);
      clear_pins(32'h2);
      chk("R3 cleared", raw_status, '0);
   endtask

   task automatic t_both;
      cfg_both[2] = 1'b1;
      cfg_polarity[2] = 1'b0;
      drive_pin(2, 1'b1);
      wait_neg(4);
      chk("R4 both-edge rising", raw_status, 32'h4);
      clear_pins(32'h4);
      drive_pin(2, 1'b0);
      wait_neg(4);
      chk("R4 both-edge falling", raw_status, 32'h4);
      clear_pins(32'h4);
      chk("R4 cleared", raw_status, '0);
   endtask

   task automatic t_partial;
      drive_pin(3, 1'b1);
      pin_in[4] = 1'b1;
      wait_neg(4);
      chk("R5 two pins latched", raw_status, 32'h18);
      clear_pins(32'h8);
      chk("R5 partial clear keeps other", raw_status, 32'h10);
      @(negedge clk);
      eoi_bits = 32'h10;
      wait_neg(2);
      chk("R5 bits without strobe ignored", raw_status, 32'h10);
      eoi_bits = '0;
      clear_pins(32'h10);
      chk("R5 second clear", raw_status, '0);
   endtask

   task automatic t_level;
      @(negedge clk);
      cfg_type[5] = 1'b0;
      cfg_polarity[5] = 1'b1;
      drive_pin(5, 1'b1);
      wait_neg(1);
      chk("R11 level not yet after 1 edge", raw_status & 32'h20, '0);
      wait_neg(1);
      chk("R11 R6 level high after 2 edges", raw_status & 32'h20, 32'h20);
      clear_pins(32'h20);
      chk("R6 eoi has no effect on level", raw_status & 32'h20, 32'h20);
      drive_pin(5, 1'b0);
      wait_neg(2);
      chk("R6 level follows pin low", raw_status & 32'h20, '0);
      @(negedge clk);
      cfg_polarity[5] = 1'b0;
      #0.5;
      chk("R6 active-low level", raw_status & 32'h20, 32'h20);
      @(negedge clk);
      cfg_polarity[5] = 1'b1;
      cfg_type[5] = 1'b1;
      wait_neg(1);
      chk("R6 back to edge idle", raw_status, '0);
   endtask

   task automatic t_mask;
      @(negedge clk);
      cfg_mask[6] = 1'b1;
      drive_pin(6, 1'b1);
      wait_neg(5);
      chk("R7 raw set while masked", raw_status, 32'h40);
      chk("R7 status hidden", int_status, '0);
      chk("R7 irq quiet while masked", {{(N-1){1'b0}}, irq}, '0);
      cfg_mask[6] = 1'b0;
      wait_neg(1);
      chk("R7 unmask reveals", int_status, 32'h40);
      chk("R9 irq after unmask", {{(N-1){1'b0}}, irq}, 32'h1);
      cfg_enable[6] = 1'b0;
      wait_neg(1);
      chk("R8 disabled hidden", int_status, '0);
      chk("R8 raw still set", raw_status, 32'h40);
      cfg_enable[6] = 1'b1;
      clear_pins(32'h40);
      chk("R7 cleared", raw_status, '0);
   endtask

   task automatic t_collision;
      cfg_both[7] = 1'b1;
      drive_pin(7, 1'b1);
      wait_neg(4);
      chk("R10 first edge latched", raw_status, 32'h80);
      drive_pin(7, 1'b0);
      wait_neg(2);
      eoi_wr = 1'b1;
      eoi_bits = 32'h80;
      @(negedge clk);
      eoi_wr = 1'b0;
      eoi_bits = '0;
      chk("R10 edge wins over same-cycle clear", raw_status, 32'h80);
      clear_pins(32'h80);
      chk("R10 later clear works", raw_status, '0);
   endtask

   initial begin
      wait_neg(3);
      rst_n = 1'b1;
      wait_neg(2);
      t_reset();
      t_rising();
      t_falling();
      t_both();
      t_partial();
      t_level();
      t_mask();
      t_collision();
      if (!finished) begin
         finished = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fails++;
         $display("FAIL watchdog act=running exp=done");
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

endmodule